// File: doc/BRIEF.md
# Frame-Counter PWM Generator with Conversion and Load Strobes

This block turns an 8-bit duty word into a pulse-width-modulated line. A free-running frame counter steps once per clock and wraps after 256 counts. The PWM line is high for the counts below the duty value of the current frame. The same counter sets two fixed points in each frame. At count 128 the block raises a one-cycle request that starts an analog-to-digital conversion. At count 200 it raises a one-cycle load enable for the downstream deviation stage. The conversion result is therefore taken at mid-frame, and the controller updates a fixed 72 cycles later.

A small phase state machine tracks where the frame stands and produces both strobes. Its five states are PH_HEAD (counts 0 to 127), PH_ADC (count 128), PH_MID (counts 129 to 199), PH_LOAD (count 200) and PH_TAIL (counts 201 to 255). It has five transitions:
- `head_to_adc`, taken at count 127.
- `adc_to_mid`, taken unconditionally.
- `mid_to_load`, taken at count 199.
- `load_to_tail`, taken unconditionally.
- `tail_to_head`, taken at count 255, when the counter wraps.

The duty word is captured at count 0 of every frame, so a frame is never cut short. All three outputs pass through one output register and then a delay line of `OUT_DELAY` stages. This models the latency of the surrounding pipeline.

Top module: `pwm_strobe_gen`

## Requirements
- R1: The frame counter starts at 0 after reset, increments by one per clock and wraps from 255 to 0. As a result, consecutive conversion requests are exactly 256 cycles apart.
- R2: For a frame with duty value d, the PWM output is high for the counts c with c < d and low for all other counts of that frame.
- R3: The duty input is sampled only in the cycle where the count is 0. A change of `duty_i` at any other count has no effect until the next frame.
- R4: Duty 0 gives a PWM output that stays low for the whole frame. Duty 255 gives 255 high cycles and 1 low cycle per 256-cycle frame.
- R5: `adc_req_o` is high for exactly one cycle per frame, corresponding to count 128.
- R6: `load_o` is high for exactly one cycle per frame, corresponding to count 200. This is 72 cycles after the conversion request.
- R7: Every output shows the value for count c exactly 1 + `OUT_DELAY` clock cycles after the counter held c. `OUT_DELAY` = 0 leaves only the single output register.
- R8: While reset is high, all outputs are low. After release, the counter restarts at 0 and the delay line starts empty (all low).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state element changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| duty_i | input | 8 | Duty word, sampled at count 0 of each frame |
| pwm_o | output | 1 | Delayed PWM line |
| adc_req_o | output | 1 | Delayed one-cycle conversion request (count 128) |
| load_o | output | 1 | Delayed one-cycle load enable (count 200) |

## Verification
The hardest situation to reach from the ports is a duty change in the middle of a frame, because the frame position is never visible directly. The stimulus follows the count in its own reference and changes `duty_i` at count 60. It then counts the high cycles of the rest of that frame and of the whole next frame, and compares them with the old and the new duty word. A second delicate point is the empty delay line right after reset. It is checked by requiring the first PWM pulse to appear at exactly cycle 1 + `OUT_DELAY` after release.

// File: rtl/pwm_strobe_pkg.sv
package pwm_strobe_pkg;

    typedef enum logic [2:0] {
        PH_HEAD,
        PH_ADC,
        PH_MID,
        PH_LOAD,
        PH_TAIL
    } frame_phase_e;

    typedef struct packed {
        logic pwm;
        logic adc;
        logic load;
    } out_bits_t;

    localparam int OUT_BITS_W = $bits(out_bits_t);

endpackage

// File: rtl/pwm_frame_counter.sv
module pwm_frame_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
        end else begin
            cnt_o <= cnt_o + CNT_W'(1);
        end
    end

    // R1: wrap from the last count to zero
    assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (cnt_o == CNT_LAST) |=> (cnt_o == '0));

    // R1: single step otherwise
    assert_step_R1: assert property (@(posedge clk) disable iff (rst)
        (cnt_o != CNT_LAST) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

endmodule

// File: rtl/pwm_phase_fsm.sv
module pwm_phase_fsm
    import pwm_strobe_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int ADC_POINT  = 128,
    parameter int LOAD_POINT = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             adc_o,
    output logic             load_o
);
    localparam logic [CNT_W-1:0] ADC_PRE  = CNT_W'(ADC_POINT - 1);
    localparam logic [CNT_W-1:0] LOAD_PRE = CNT_W'(LOAD_POINT - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = '1;
    localparam logic [CNT_W-1:0] ADC_AT   = CNT_W'(ADC_POINT);
    localparam logic [CNT_W-1:0] LOAD_AT  = CNT_W'(LOAD_POINT);

    frame_phase_e state_q;
    frame_phase_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_HEAD: if (cnt_i == ADC_PRE)  state_d = PH_ADC;   // head_to_adc
            PH_ADC:                         state_d = PH_MID;   // adc_to_mid
            PH_MID:  if (cnt_i == LOAD_PRE) state_d = PH_LOAD;  // mid_to_load
            PH_LOAD:                        state_d = PH_TAIL;  // load_to_tail
            PH_TAIL: if (cnt_i == CNT_LAST) state_d = PH_HEAD;  // tail_to_head
            default:                        state_d = PH_HEAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_HEAD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        adc_o  = 1'b0;
        load_o = 1'b0;
        unique case (state_q)
            PH_ADC:  adc_o  = 1'b1;
            PH_LOAD: load_o = 1'b1;
            default: begin
                adc_o  = 1'b0;
                load_o = 1'b0;
            end
        endcase
    end

    // R5: conversion request exactly at its count
    assert_adc_point_R5: assert property (@(posedge clk) disable iff (rst)
        adc_o == (cnt_i == ADC_AT));

    // R6: load strobe exactly at its count
    assert_load_point_R6: assert property (@(posedge clk) disable iff (rst)
        load_o == (cnt_i == LOAD_AT));

    // R5: request never lasts two cycles
    assert_adc_single_R5: assert property (@(posedge clk) disable iff (rst)
        adc_o |=> !adc_o);

endmodule

// File: rtl/pwm_duty_compare.sv
module pwm_duty_compare #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic             pwm_o
);
    logic [CNT_W-1:0] duty_q;
    logic [CNT_W-1:0] duty_eff;
    logic             frame_start;

    assign frame_start = (cnt_i == '0);
    assign duty_eff    = frame_start ? duty_i : duty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= '0;
        end else if (frame_start) begin
            duty_q <= duty_i;
        end
    end

    always_comb begin
        pwm_o = (cnt_i < duty_eff);
    end

    // R3: captured duty only moves at a frame start
    assert_duty_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt_i != '0) |=> (duty_q == $past(duty_q)));

endmodule

// File: rtl/pwm_delay_line.sv
module pwm_delay_line #(
    parameter int W     = 3,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        if (DEPTH == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_shift
            logic [W-1:0] stage_q [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
                end else begin
                    stage_q[0] <= d_i;
                    for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
                end
            end
            assign q_o = stage_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/pwm_strobe_gen.sv
module pwm_strobe_gen
    import pwm_strobe_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int ADC_POINT  = 128,
    parameter int LOAD_POINT = 200,
    parameter int OUT_DELAY  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] duty_i,
    output logic             pwm_o,
    output logic             adc_req_o,
    output logic             load_o
);
    logic [CNT_W-1:0] cnt;
    logic             pwm_raw;
    logic             adc_raw;
    logic             load_raw;
    out_bits_t        out_q;
    out_bits_t        out_dly;

    pwm_frame_counter #(.CNT_W(CNT_W)) counter_i (
        .clk   (clk),
        .rst   (rst),
        .cnt_o (cnt)
    );

    pwm_phase_fsm #(
        .CNT_W      (CNT_W),
        .ADC_POINT  (ADC_POINT),
        .LOAD_POINT (LOAD_POINT)
    ) phase_i (
        .clk    (clk),
        .rst    (rst),
        .cnt_i  (cnt),
        .adc_o  (adc_raw),
        .load_o (load_raw)
    );

    pwm_duty_compare #(.CNT_W(CNT_W)) compare_i (
        .clk    (clk),
        .rst    (rst),
        .cnt_i  (cnt),
        .duty_i (duty_i),
        .pwm_o  (pwm_raw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= '{pwm: pwm_raw, adc: adc_raw, load: load_raw};
        end
    end

    pwm_delay_line #(.W(OUT_BITS_W), .DEPTH(OUT_DELAY)) delay_i (
        .clk (clk),
        .rst (rst),
        .d_i (out_q),
        .q_o (out_dly)
    );

    assign pwm_o     = out_dly.pwm;
    assign adc_req_o = out_dly.adc;
    assign load_o    = out_dly.load;

    // R8: one cycle of reset leaves every output low
    assert_reset_low_R8: assert property (@(posedge clk)
        rst |=> (!pwm_o && !adc_req_o && !load_o));

    // R5, R6: the two strobes never coincide
    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(adc_req_o && load_o));

endmodule

// File: tb/pwm_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module pwm_strobe_gen_tb_top;
    localparam int D   = 3;
    localparam int LAT = D + 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] duty = 8'd0;
    logic       pwm, adc, ld;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    pwm_strobe_gen #(.OUT_DELAY(D)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .duty_i    (duty),
        .pwm_o     (pwm),
        .adc_req_o (adc),
        .load_o    (ld)
    );

    // requirement-level reference: count, frame duty, output lag
    int         rc;
    logic [7:0] rd;
    logic [2:0] rpipe [0:D];

    always @(posedge clk) begin
        logic [7:0] dd;
        if (rst) begin
            rc <= 0;
            rd <= 8'd0;
            for (int i = 0; i <= D; i++) rpipe[i] <= 3'b000;
        end else begin
            dd = (rc == 0) ? duty : rd;
            if (rc == 0) rd <= duty;
            rpipe[0] <= {(rc < int'(dd)), (rc == 128), (rc == 200)};
            for (int i = 1; i <= D; i++) rpipe[i] <= rpipe[i-1];
            rc <= (rc + 1) % 256;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycle_cmp(input string tag);
        @(negedge clk);
        chk({pwm, adc, ld} === rpipe[D], tag, int'({pwm, adc, ld}), int'(rpipe[D]));
    endtask

    task automatic t_reset(input logic [7:0] d);
        rst  = 1'b1;
        duty = d;
        repeat (5) begin
            @(negedge clk);
            chk({pwm, adc, ld} === 3'b000, "R8 outputs low in reset", int'({pwm, adc, ld}), 0);
        end
        rst = 1'b0;
        for (int i = 1; i <= LAT; i++) begin
            @(negedge clk);
            chk(pwm === (i == LAT), "R7 first pwm pulse latency", int'(pwm), int'(i == LAT));
            chk({adc, ld} === 2'b00, "R8 empty delay line", int'({adc, ld}), 0);
        end
    endtask

    task automatic t_frames(input logic [7:0] d, input string tag);
        int hi = 0, na = 0, nl = 0;
        duty = d;
        repeat (256) cycle_cmp(tag);
        repeat (256) begin
            cycle_cmp(tag);
            hi += int'(pwm);
            na += int'(adc);
            nl += int'(ld);
        end
        chk(hi == int'(d), {tag, " high cycles per frame"}, hi, int'(d));
        chk(na == 1, "R5 one request per frame", na, 1);
        chk(nl == 1, "R6 one load per frame", nl, 1);
    endtask

    task automatic t_spacing();
        int t = 0, ta1 = -1, ta2 = -1, tl = -1;
        while (ta2 < 0 && t < 700) begin
            cycle_cmp("R1 lockstep");
            t++;
            if (adc) begin
                if (ta1 < 0) ta1 = t;
                else ta2 = t;
            end
            if (ld && ta1 >= 0 && tl < 0) tl = t;
        end
        chk(ta2 - ta1 == 256, "R1 request period", ta2 - ta1, 256);
        chk(tl - ta1 == 72, "R6 load after request", tl - ta1, 72);
    endtask

    task automatic t_midchange();
        int hi = 0;
        duty = 8'd40;
        repeat (512) cycle_cmp("R3 lockstep");
        while (rc != 60) cycle_cmp("R3 lockstep");
        duty = 8'd200;
        forever begin
            cycle_cmp("R3 lockstep");
            if (rc == LAT) break;
            hi += int'(pwm);
        end
        chk(hi == 0, "R3 rest of frame keeps old duty", hi, 0);
        hi = int'(pwm);
        repeat (255) begin
            cycle_cmp("R3 lockstep");
            hi += int'(pwm);
        end
        chk(hi == 200, "R3 next frame uses new duty", hi, 200);
    endtask

    initial begin
        t_reset(8'd77);
        t_frames(8'd100, "R2");
        t_frames(8'd0, "R4 duty zero");
        t_frames(8'd255, "R4 duty max");
        t_frames(8'd1, "R2 duty one");
        t_spacing();
        t_midchange();
        t_reset(8'd9);
        t_frames(8'd128, "R2 after reset");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule